// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This clocked unit owns the two 32-bit result registers, HI and LO, that sit beside a processor's main ALU. It performs 32-bit multiplication and division on two source operands, as signed or as unsigned values, and writes the 64-bit outcome into the register pair. It also writes either register directly from the first operand, and it returns either register on a read port.

Each request is one cycle of `req_valid` with a 6-bit function code. Reads and direct writes finish in a single cycle. Multiply and divide run iteratively and hold `busy` high until they finish. The multiplier uses shift-add on operand magnitudes. The divider is a restoring divider. When the operation is signed, one correction step sets the signs when the operation completes.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, HI and LO both read as zero and `busy` is low.
- R2: Code 011000 (signed) and code 011001 (unsigned) multiply `src_a` by `src_b`. HI gets the upper 32 bits of the 64-bit product and LO gets the lower 32 bits.
- R3: Code 011010 (signed) and code 011011 (unsigned) divide `src_a` by `src_b`. LO gets the quotient and HI gets the remainder. A signed quotient truncates toward zero, and a signed remainder carries the sign of the dividend.
- R4: Code 010001 writes `src_a` into HI and code 010011 writes `src_a` into LO. The write takes effect on the next clock edge when `busy` is low.
- R5: A multiply or divide accepted while idle raises `busy` at the next edge. `busy` stays high for exactly 32 cycles. HI and LO both change on the edge at which `busy` falls.
- R6: A divide whose divisor is zero runs its full 32 busy cycles and leaves HI and LO unchanged.
- R7: While `busy` is high, direct writes and new multiply or divide requests are ignored. HI and LO hold their values until the running operation completes.
- R8: With `req_valid` high, code 010000 drives HI onto `rd_data` and code 010010 drives LO, both in the same cycle. In every other cycle `rd_data` is zero. A read taken while `busy` is high returns the value from before the operation.
- R9: Any code not listed above leaves HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_code | input | 6 | Function code of the request |
| src_a | input | 32 | First operand: the multiplicand or dividend, and the data for direct writes |
| src_b | input | 32 | Second operand: the multiplier or divisor |
| rd_data | output | 32 | Value of HI or LO for a read request, zero otherwise |
| busy | output | 1 | A multiply or divide is in progress |

## Verification
The collisions that matter happen while a long operation is running and another request arrives. In one case a direct write lands in the last busy cycle, one edge before the result commits. In another, a read or a second multiply arrives while the first is still iterating. The bench starts a multiply, issues a read and a competing multiply inside the busy window, and then places a write to HI exactly in the final busy cycle. It judges the outcome by the read returning the old HI value, by `busy` lasting exactly 32 cycles, and by later reads returning the first product with no trace of the late write.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
    localparam logic [5:0] CODE_RD_HI  = 6'b010000;
    localparam logic [5:0] CODE_WR_HI  = 6'b010001;
    localparam logic [5:0] CODE_RD_LO  = 6'b010010;
    localparam logic [5:0] CODE_WR_LO  = 6'b010011;
    localparam logic [5:0] CODE_MUL_S  = 6'b011000;
    localparam logic [5:0] CODE_MUL_U  = 6'b011001;
    localparam logic [5:0] CODE_DIV_S  = 6'b011010;
    localparam logic [5:0] CODE_DIV_U  = 6'b011011;

    typedef enum logic {
        KIND_MUL = 1'b0,
        KIND_DIV = 1'b1
    } kind_e;
endpackage

// File: rtl/hilo_mul_step.sv
// One shift-add iteration: add the multiplicand into the upper half when the
// multiplier LSB is set, then shift the whole pair right by one.
module hilo_mul_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_hi,
    input  logic [W-1:0] cur_lo,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, cur_hi} + (cur_lo[0] ? {1'b0, mcand} : '0);
        nxt_hi = sum[W:1];
        nxt_lo = {sum[0], cur_lo[W-1:1]};
    end
endmodule

// File: rtl/hilo_div_step.sv
// One restoring-division iteration: shift the next dividend bit into the
// partial remainder and subtract the divisor when it fits.
module hilo_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_rem,
    input  logic [W-1:0] cur_quo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] nxt_rem,
    output logic [W-1:0] nxt_quo
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {cur_rem, cur_quo[W-1]};
        diff    = shifted - {1'b0, divisor};
        fits    = ~diff[W];
        nxt_rem = fits ? diff[W-1:0] : shifted[W-1:0];
        nxt_quo = {cur_quo[W-2:0], fits};
    end
endmodule

// File: rtl/hilo_sign_fix.sv
// Final correction from magnitude results to signed results.
module hilo_sign_fix #(
    parameter int W = 32
) (
    input  hilo_pkg::kind_e kind,
    input  logic            neg_lo,
    input  logic            neg_hi,
    input  logic [W-1:0]    raw_hi,
    input  logic [W-1:0]    raw_lo,
    output logic [W-1:0]    out_hi,
    output logic [W-1:0]    out_lo
);
    logic [2*W-1:0] wide;

    always_comb begin
        wide = {raw_hi, raw_lo};
        if (kind == hilo_pkg::KIND_MUL) begin
            if (neg_lo) wide = -wide;
            out_hi = wide[2*W-1:W];
            out_lo = wide[W-1:0];
        end else begin
            out_lo = neg_lo ? -raw_lo : raw_lo;
            out_hi = neg_hi ? -raw_hi : raw_hi;
        end
    end
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [5:0]   req_code,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic [W-1:0] rd_data,
    output logic         busy
);
    import hilo_pkg::*;

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
        logic          busy;
        logic [CW-1:0] cnt;
        kind_e         kind;
        logic          neg_lo;
        logic          neg_hi;
        logic          dz;
        logic [W-1:0]  wk_hi;
        logic [W-1:0]  wk_lo;
        logic [W-1:0]  opnd;
    } state_t;

    state_t st_d, st_q;

    logic         is_mul, is_div, is_signed;
    logic         a_neg, b_neg;
    logic [W-1:0] mag_a, mag_b;
    logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo;
    logic [W-1:0] step_hi, step_lo;
    logic [W-1:0] fix_hi, fix_lo;
    logic [W-1:0] hi_view, lo_view;

    hilo_mul_step #(.W(W)) u_mul_step (
        .cur_hi (st_q.wk_hi),
        .cur_lo (st_q.wk_lo),
        .mcand  (st_q.opnd),
        .nxt_hi (mul_hi),
        .nxt_lo (mul_lo)
    );

    hilo_div_step #(.W(W)) u_div_step (
        .cur_rem (st_q.wk_hi),
        .cur_quo (st_q.wk_lo),
        .divisor (st_q.opnd),
        .nxt_rem (div_hi),
        .nxt_quo (div_lo)
    );

    hilo_sign_fix #(.W(W)) u_sign_fix (
        .kind   (st_q.kind),
        .neg_lo (st_q.neg_lo),
        .neg_hi (st_q.neg_hi),
        .raw_hi (step_hi),
        .raw_lo (step_lo),
        .out_hi (fix_hi),
        .out_lo (fix_lo)
    );

    always_comb begin
        is_mul    = (req_code == CODE_MUL_S) || (req_code == CODE_MUL_U);
        is_div    = (req_code == CODE_DIV_S) || (req_code == CODE_DIV_U);
        is_signed = ~req_code[0];
        a_neg     = is_signed & src_a[W-1];
        b_neg     = is_signed & src_b[W-1];
        mag_a     = a_neg ? -src_a : src_a;
        mag_b     = b_neg ? -src_b : src_b;
        step_hi   = (st_q.kind == KIND_MUL) ? mul_hi : div_hi;
        step_lo   = (st_q.kind == KIND_MUL) ? mul_lo : div_lo;
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid) begin
                if (req_code == CODE_WR_HI) st_d.hi = src_a;
                if (req_code == CODE_WR_LO) st_d.lo = src_a;
                if (is_mul || is_div) begin
                    st_d.busy   = 1'b1;
                    st_d.cnt    = '0;
                    st_d.neg_lo = a_neg ^ b_neg;
                    st_d.wk_hi  = '0;
                    if (is_mul) begin
                        st_d.kind   = KIND_MUL;
                        st_d.neg_hi = 1'b0;
                        st_d.dz     = 1'b0;
                        st_d.wk_lo  = mag_b;
                        st_d.opnd   = mag_a;
                    end else begin
                        st_d.kind   = KIND_DIV;
                        st_d.neg_hi = a_neg;
                        st_d.dz     = (src_b == '0);
                        st_d.wk_lo  = mag_a;
                        st_d.opnd   = mag_b;
                    end
                end
            end
        end else begin
            st_d.wk_hi = step_hi;
            st_d.wk_lo = step_lo;
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_STEP) begin
                st_d.busy = 1'b0;
                if (!st_q.dz) begin
                    st_d.hi = fix_hi;
                    st_d.lo = fix_lo;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (req_valid && req_code == CODE_RD_HI) rd_data = st_q.hi;
        if (req_valid && req_code == CODE_RD_LO) rd_data = st_q.lo;
    end

    assign busy    = st_q.busy;
    assign hi_view = st_q.hi;
    assign lo_view = st_q.lo;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [5:0]   req_code,
    input logic [W-1:0] src_a,
    input logic         busy,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);
    import hilo_pkg::*;

    localparam int RW = $clog2(W) + 2;

    logic [RW-1:0] run_cnt;
    logic          long_req, wr_req;

    assign long_req = req_valid && (req_code == CODE_MUL_S || req_code == CODE_MUL_U ||
                                    req_code == CODE_DIV_S || req_code == CODE_DIV_U);
    assign wr_req   = req_valid && (req_code == CODE_WR_HI || req_code == CODE_WR_LO);

    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    AST_WR_HI_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_code == CODE_WR_HI) |=> (hi == $past(src_a))); // R4
    AST_WR_LO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_code == CODE_WR_LO) |=> (lo == $past(src_a))); // R4
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && long_req) |=> busy); // R5
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < RW'(W))); // R5
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == RW'(W))); // R5
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(hi) && $stable(lo)))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_req) |=> ($stable(hi) && $stable(lo))); // R9
endmodule

bind hilo_muldiv_unit hilo_muldiv_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_code  (req_code),
    .src_a     (src_a),
    .busy      (busy),
    .hi        (hi_view),
    .lo        (lo_view)
);

// File: tb/hilo_muldiv_unit_bench.sv
`timescale 1ns/1ps
module hilo_muldiv_unit_bench;
    import hilo_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_code = 6'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] rd_data;
    logic        busy;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    hilo_muldiv_unit u_hilo_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .src_a(src_a), .src_b(src_b), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected value for every read request it sees.
    always @(negedge clk) begin
        if (rst_n && req_valid && (req_code == CODE_RD_HI || req_code == CODE_RD_LO)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected read", {32'b0, rd_data}, 64'b0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, {32'b0, rd_data}, {32'b0, e});
            end
        end
    end

    task automatic issue(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk); #1;
        req_valid = 1'b1; req_code = c; src_a = a; src_b = b;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        req_valid = 1'b0; req_code = 6'b0;
    endtask

    task automatic read_pair(input string tag);
        exp_q.push_back(m_hi); tag_q.push_back({tag, " HI"});
        issue(CODE_RD_HI, '0, '0);
        exp_q.push_back(m_lo); tag_q.push_back({tag, " LO"});
        issue(CODE_RD_LO, '0, '0);
        idle();
    endtask

    task automatic model(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b);
        longint      p, q, r;
        logic [63:0] u;
        case (c)
            CODE_MUL_S: begin
                p = longint'($signed(a)) * longint'($signed(b));
                m_hi = p[63:32]; m_lo = p[31:0];
            end
            CODE_MUL_U: begin
                u = {32'b0, a} * {32'b0, b};
                m_hi = u[63:32]; m_lo = u[31:0];
            end
            CODE_DIV_S: if (b != 0) begin
                q = longint'($signed(a)) / longint'($signed(b));
                r = longint'($signed(a)) % longint'($signed(b));
                m_lo = q[31:0]; m_hi = r[31:0];
            end
            CODE_DIV_U: if (b != 0) begin
                m_lo = a / b; m_hi = a % b;
            end
            default: ;
        endcase
    endtask

    task automatic run_long(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b, input string tag);
        int n;
        issue(c, a, b);
        idle();
        n = busy ? 1 : 0;
        while (busy && n < 100) begin
            @(posedge clk); #1;
            if (busy) n++;
        end
        check(n == 32, "R5 busy span", 64'(n), 64'd32);
        model(c, a, b);
        read_pair(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        check(rd_data == 32'b0, "R8 idle read port", 64'(rd_data), 64'd0);
        read_pair("R1 reset");

        // R4: direct writes, read immediately after
        issue(CODE_WR_HI, 32'h1234_5678, '0);
        issue(CODE_WR_LO, 32'h9abc_def0, '0);
        m_hi = 32'h1234_5678; m_lo = 32'h9abc_def0;
        read_pair("R4 direct write");

        // R9: unlisted code leaves state alone
        issue(6'b100000, 32'hffff_ffff, 32'h1);
        issue(6'b010100, 32'h5555_5555, 32'h0);
        idle();
        read_pair("R9 ignored code");

        // R2: multiply cases
        run_long(CODE_MUL_S, 32'hffff_fff9, 32'd6, "R2 signed neg*pos");
        run_long(CODE_MUL_S, 32'hffff_ffff, 32'hffff_ffff, "R2 signed -1*-1");
        run_long(CODE_MUL_U, 32'hffff_ffff, 32'hffff_ffff, "R2 unsigned max*max");
        run_long(CODE_MUL_S, 32'h8000_0000, 32'h8000_0000, "R2 signed min*min");
        run_long(CODE_MUL_U, 32'h0001_0003, 32'h0000_0000, "R2 unsigned by zero");

        // R3: divide cases
        run_long(CODE_DIV_S, 32'hffff_fff9, 32'd2, "R3 signed -7/2");
        run_long(CODE_DIV_S, 32'd7, 32'hffff_fffe, "R3 signed 7/-2");
        run_long(CODE_DIV_U, 32'hffff_ffff, 32'd3, "R3 unsigned max/3");
        run_long(CODE_DIV_S, 32'h8000_0000, 32'hffff_ffff, "R3 signed min/-1");
        run_long(CODE_DIV_U, 32'd5, 32'd9, "R3 unsigned small/large");

        // R6: divide by zero keeps HI/LO
        issue(CODE_WR_HI, 32'hcafe_0001, '0);
        issue(CODE_WR_LO, 32'hcafe_0002, '0);
        m_hi = 32'hcafe_0001; m_lo = 32'hcafe_0002;
        run_long(CODE_DIV_S, 32'd100, 32'd0, "R6 signed div by zero");
        run_long(CODE_DIV_U, 32'hffff_0000, 32'd0, "R6 unsigned div by zero");

        // R7/R8: collisions inside the busy window
        issue(CODE_MUL_U, 32'd1000, 32'd3000);
        exp_q.push_back(m_hi); tag_q.push_back("R8 read during busy");
        issue(CODE_RD_HI, '0, '0);
        check(busy == 1'b1, "R5 busy after start", 64'(busy), 64'd1);
        issue(CODE_MUL_S, 32'hffff_ffff, 32'd5);
        idle();
        repeat (28) @(posedge clk);
        issue(CODE_WR_HI, 32'hdead_beef, '0);
        check(busy == 1'b1, "R7 last busy cycle", 64'(busy), 64'd1);
        idle();
        check(busy == 1'b0, "R5 busy falls", 64'(busy), 64'd0);
        model(CODE_MUL_U, 32'd1000, 32'd3000);
        read_pair("R7 late write and second start ignored");

        // R4: direct write after the collision works again
        issue(CODE_WR_LO, 32'h0bad_f00d, '0);
        m_lo = 32'h0bad_f00d;
        read_pair("R4 write after busy");

        repeat (2) @(posedge clk);
        check(exp_q.size() == 0, "R8 all reads seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule